// File: doc/BRIEF.md
# Avionics Serial Word Transmitter

This block turns 32-bit avionics data words into a two-wire digital return-to-zero pair. The pair is meant for an external line driver. The A wire pulses for a one, the B wire pulses for a zero, and both wires stay low for null. A host loads each word over a 16-bit parallel bus in two writes. Complete words wait in a 32-entry queue. While the enable input is high, the block sends the queued words in arrival order and puts a null gap between them.

The configuration inputs choose between two bit rates, derived from the block clock by dividing it by 10 or by 80. They also choose whether bit 32 carries host data or a generated parity bit, and whether that parity is odd or even. A self-test input moves the serial output away from the line pair and onto a loopback pair that feeds a local receiver. The queue reports its fill level through empty, half-full and full flags. The full and half-full flags also have active-low copies.

Top module: `avx_word_tx`

## Requirements
- R1: After reset the queue reads empty (`q_empty`=1, `q_half`=0, `q_full`=0, `q_half_n`=1, `q_full_n`=1), and all four serial outputs are low.
- R2: The first accepted write (`wr_en` high for one clock) supplies word bits 16:1 from `wr_data[15:0]`. The next accepted write supplies bits 32:17, and only that second write places the word in the queue.
- R3: `q_empty` is 1 exactly when the queue holds 0 words. `q_half` is 1 when it holds 16 or more. `q_full` is 1 when it holds 32. `q_half_n` and `q_full_n` are the inverses of `q_half` and `q_full`.
- R4: A write strobe that arrives while the queue holds 32 words is ignored, both for the queue contents and for the pairing of halves.
- R5: A word starts only when `tx_enable` is high and the queue is not empty. Words are sent in the order they were written, and nothing is sent while `tx_enable` is low.
- R6: Each bit cell drives its wire high for the first half of the cell and low for the second half. A one uses the A wire and a zero uses the B wire. A and B of a pair are never high together.
- R7: Bits 8 down to 1 go out first, bit 8 leading. Bits 9 through 32 then follow in ascending order.
- R8: The bit period is 10 clocks when `cfg_rate_slow`=0 and 80 clocks when it is 1. The rate is captured when each word starts.
- R9: With `cfg_par_en`=0, bit 32 is the host's bit. With `cfg_par_en`=1, bit 32 is replaced so that the 32-bit word has an odd number of ones when `cfg_par_even`=0, or an even number when it is 1. The parity settings are captured at word start.
- R10: Consecutive words are separated by at least four bit periods of null after the last cell of the earlier word ends.
- R11: With `cfg_run_normal`=0 (self test) the serial cells appear on `loop_a`/`loop_b` and the line pair stays low. With `cfg_run_normal`=1 the cells appear on `line_a`/`line_b` and the loopback pair stays low.
- R12: When a word is completed by a write in the same clock that a word is taken for transmission, the queue fill level, and so every flag, is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Half-word write strobe |
| wr_data | input | 16 | Half-word being written |
| cfg_rate_slow | input | 1 | 0: clock/10 bit rate, 1: clock/80 |
| cfg_par_en | input | 1 | 1: bit 32 is generated parity |
| cfg_par_even | input | 1 | 0: odd parity, 1: even parity |
| cfg_run_normal | input | 1 | 1: line pair active, 0: loopback self test |
| tx_enable | input | 1 | Allows word transmission to start |
| line_a | output | 1 | Line pair, ones wire |
| line_b | output | 1 | Line pair, zeros wire |
| loop_a | output | 1 | Loopback pair, ones wire |
| loop_b | output | 1 | Loopback pair, zeros wire |
| q_empty | output | 1 | Queue holds no words |
| q_half | output | 1 | Queue holds 16 or more words |
| q_full | output | 1 | Queue holds 32 words |
| q_half_n | output | 1 | Active-low half-full |
| q_full_n | output | 1 | Active-low full |

## Verification
A host write that completes a word and the serializer taking the queue head for a new word can happen on the same clock edge. The bench provokes this by holding 16 words with enable low, writing the first half of a 17th word, and then raising `tx_enable` and the second-half strobe together. On the next falling edge the fill level must still be 16: `q_half` stays 1 and `q_empty` stays 0, and the line must already show the first cell of the popped word. Afterwards all 17 words must decode in order. That ordering shows that neither the push nor the pop was lost.

// File: rtl/avx_tx_pkg.sv
package avx_tx_pkg;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_SEND = 2'd1,
        SER_GAP  = 2'd2
    } ser_state_e;

    // Wire order: slot 0..7 carry bits 8..1, slots 8..31 carry bits 9..32
    function automatic logic [31:0] wire_order(input logic [31:0] w);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) begin
            o[i] = (i < 8) ? w[7 - i] : w[i];
        end
        return o;
    endfunction

endpackage

// File: rtl/avx_tx_fifo.sv
module avx_tx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             half,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         fifo_q, fifo_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_push, do_pop;

    assign full  = (fifo_q.cnt == CW'(DEPTH));
    assign empty = (fifo_q.cnt == '0);
    assign half  = (fifo_q.cnt >= CW'(DEPTH / 2));
    assign head  = mem_q[fifo_q.rp];

    always_comb begin
        fifo_d  = fifo_q;
        do_push = push & ~full;
        do_pop  = pop & ~empty;
        if (do_push) begin
            fifo_d.wp = (fifo_q.wp == AW'(DEPTH - 1)) ? '0 : fifo_q.wp + 1'b1;
        end
        if (do_pop) begin
            fifo_d.rp = (fifo_q.rp == AW'(DEPTH - 1)) ? '0 : fifo_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[fifo_q.wp] <= push_data;
    end

endmodule

// File: rtl/avx_tx_ser.sv
module avx_tx_ser
    import avx_tx_pkg::*;
#(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_ok,
    input  logic [31:0] word,
    input  logic        rate_slow,
    input  logic        par_en,
    input  logic        par_even,
    output logic        pop,
    output logic        cell_a,
    output logic        cell_b
);
    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int PW      = $clog2(DIV_MAX);
    localparam int GW      = $clog2(GAP_BITS + 1);

    typedef struct packed {
        ser_state_e     state;
        logic           slow;
        logic [4:0]     bitn;
        logic [PW-1:0]  phase;
        logic [GW-1:0]  gapn;
        logic [31:0]    ord;
    } ser_st_t;

    ser_st_t     ser_q, ser_d;
    logic [PW-1:0] last_ph, half_ph;
    logic [31:0]   w_eff;
    logic          cell_hi;

    assign last_ph = ser_q.slow ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
    assign half_ph = ser_q.slow ? PW'(DIV_SLOW / 2) : PW'(DIV_FAST / 2);

    always_comb begin
        w_eff     = word;
        w_eff[31] = par_en ? (par_even ? ^word[30:0] : ~^word[30:0]) : word[31];
    end

    always_comb begin
        ser_d = ser_q;
        pop   = 1'b0;
        unique case (ser_q.state)
            SER_IDLE: begin
                if (start_ok) begin
                    pop         = 1'b1;
                    ser_d.state = SER_SEND;
                    ser_d.slow  = rate_slow;
                    ser_d.ord   = wire_order(w_eff);
                    ser_d.bitn  = '0;
                    ser_d.phase = '0;
                end
            end
            SER_SEND: begin
                if (ser_q.phase == last_ph) begin
                    ser_d.phase = '0;
                    if (ser_q.bitn == 5'd31) begin
                        ser_d.state = SER_GAP;
                        ser_d.gapn  = '0;
                    end else begin
                        ser_d.bitn = ser_q.bitn + 1'b1;
                    end
                end else begin
                    ser_d.phase = ser_q.phase + 1'b1;
                end
            end
            SER_GAP: begin
                if (ser_q.phase == last_ph) begin
                    ser_d.phase = '0;
                    if (ser_q.gapn == GW'(GAP_BITS - 1)) ser_d.state = SER_IDLE;
                    else                                  ser_d.gapn  = ser_q.gapn + 1'b1;
                end else begin
                    ser_d.phase = ser_q.phase + 1'b1;
                end
            end
            default: ser_d.state = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '{state: SER_IDLE, default: '0};
        else        ser_q <= ser_d;
    end

    assign cell_hi = (ser_q.state == SER_SEND) && (ser_q.phase < half_ph);
    assign cell_a  = cell_hi &  ser_q.ord[ser_q.bitn];
    assign cell_b  = cell_hi & ~ser_q.ord[ser_q.bitn];

endmodule

// File: rtl/avx_word_tx.sv
module avx_word_tx #(
    parameter int DEPTH    = 32,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        cfg_rate_slow,
    input  logic        cfg_par_en,
    input  logic        cfg_par_even,
    input  logic        cfg_run_normal,
    input  logic        tx_enable,
    output logic        line_a,
    output logic        line_b,
    output logic        loop_a,
    output logic        loop_b,
    output logic        q_empty,
    output logic        q_half,
    output logic        q_full,
    output logic        q_half_n,
    output logic        q_full_n
);
    typedef struct packed {
        logic        have_lo;
        logic [15:0] lo;
    } ld_st_t;

    ld_st_t      ld_q, ld_d;
    logic        ld_push;
    logic        ser_pop;
    logic [31:0] head;
    logic        cell_a, cell_b;

    // Half-word pairing; strobes are dropped while the queue is full
    always_comb begin
        ld_d    = ld_q;
        ld_push = 1'b0;
        if (wr_en && !q_full) begin
            if (!ld_q.have_lo) begin
                ld_d.lo      = wr_data;
                ld_d.have_lo = 1'b1;
            end else begin
                ld_push      = 1'b1;
                ld_d.have_lo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    avx_tx_fifo #(.WIDTH(32), .DEPTH(DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ld_push),
        .push_data ({wr_data, ld_q.lo}),
        .pop       (ser_pop),
        .head      (head),
        .empty     (q_empty),
        .half      (q_half),
        .full      (q_full)
    );

    avx_tx_ser #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .GAP_BITS(GAP_BITS)) i_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (tx_enable & ~q_empty),
        .word      (head),
        .rate_slow (cfg_rate_slow),
        .par_en    (cfg_par_en),
        .par_even  (cfg_par_even),
        .pop       (ser_pop),
        .cell_a    (cell_a),
        .cell_b    (cell_b)
    );

    assign line_a   = cfg_run_normal  & cell_a;
    assign line_b   = cfg_run_normal  & cell_b;
    assign loop_a   = ~cfg_run_normal & cell_a;
    assign loop_b   = ~cfg_run_normal & cell_b;
    assign q_half_n = ~q_half;
    assign q_full_n = ~q_full;

endmodule

// File: rtl/avx_word_tx_chk.sv
module avx_word_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic push,
    input logic pop,
    input logic tx_enable,
    input logic q_empty,
    input logic q_half,
    input logic q_full,
    input logic line_a,
    input logic line_b,
    input logic loop_a,
    input logic loop_b
);
    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_a && line_b) && !(loop_a && loop_b)); // R6

    AST_POP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (tx_enable && !q_empty)); // R5

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !pop) |=> q_full); // R4

    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && !push) |=> q_empty); // R3

    AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> ($stable(q_empty) && $stable(q_half) && $stable(q_full))); // R12
endmodule

bind avx_word_tx avx_word_tx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ld_push),
    .pop       (ser_pop),
    .tx_enable (tx_enable),
    .q_empty   (q_empty),
    .q_half    (q_half),
    .q_full    (q_full),
    .line_a    (line_a),
    .line_b    (line_b),
    .loop_a    (loop_a),
    .loop_b    (loop_b)
);

// File: tb/test_avx_word_tx.sv
module test_avx_word_tx;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        cfg_rate_slow = 1'b0, cfg_par_en = 1'b0, cfg_par_even = 1'b0;
    logic        cfg_run_normal = 1'b1, tx_enable = 1'b0;
    logic        line_a, line_b, loop_a, loop_b;
    logic        q_empty, q_half, q_full, q_half_n, q_full_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    avx_word_tx i_avx_word_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_rate_slow(cfg_rate_slow), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_run_normal(cfg_run_normal), .tx_enable(tx_enable),
        .line_a(line_a), .line_b(line_b), .loop_a(loop_a), .loop_b(loop_b),
        .q_empty(q_empty), .q_half(q_half), .q_full(q_full),
        .q_half_n(q_half_n), .q_full_n(q_full_n)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- line monitor (decodes by the required bit order) ----
    bit          mon_loop = 1'b0;
    int          mon_div = 10;
    int          cyc = 0, last_rise = 0, nbits = 0;
    bit          prev_act = 1'b0, have_prev = 1'b0;
    logic [31:0] acc;
    logic [31:0] rx_mem [0:63];
    int          rx_cnt = 0;
    int          per_bad = 0, width_bad = 0, gap_bad = 0, both_bad = 0, quiet_bad = 0;

    always @(negedge clk) begin
        logic a, b, oa, ob, act;
        a  = mon_loop ? loop_a : line_a;
        b  = mon_loop ? loop_b : line_b;
        oa = mon_loop ? line_a : loop_a;
        ob = mon_loop ? line_b : loop_b;
        act = a | b;
        cyc++;
        if ((line_a && line_b) || (loop_a && loop_b)) both_bad++;
        if (oa || ob) quiet_bad++;
        if (act && !prev_act) begin
            if (nbits == 0) begin
                if (have_prev && (cyc - last_rise) < 5 * mon_div) gap_bad++;
            end else if ((cyc - last_rise) != mon_div) begin
                per_bad++;
            end
            if (nbits < 8) acc[7 - nbits] = a;
            else           acc[nbits]     = a;
            last_rise = cyc;
            nbits++;
            if (nbits == 32) begin
                if (rx_cnt < 64) rx_mem[rx_cnt] = acc;
                rx_cnt++;
                nbits = 0;
                have_prev = 1'b1;
            end
        end
        if (!act && prev_act && (cyc - last_rise) != mon_div / 2) width_bad++;
        prev_act = act;
    end

    task automatic mon_clear(input bit loop_sel, input int div);
        mon_loop = loop_sel; mon_div = div; nbits = 0; have_prev = 1'b0;
        rx_cnt = 0; per_bad = 0; width_bad = 0; gap_bad = 0; both_bad = 0; quiet_bad = 0;
    endtask

    // ---------------- stimulus helpers ------------------------------------
    logic [31:0] exp_mem [0:63];
    int          exp_cnt;

    function automatic logic [31:0] exp_tx(input logic [31:0] w, input bit pen, input bit pev);
        logic [31:0] r;
        bit          ones_odd;
        r = w;
        ones_odd = ($countones(w[30:0]) % 2) == 1;
        if (pen) r[31] = pev ? ones_odd : !ones_odd;
        return r;
    endfunction

    task automatic write_half(input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        write_half(w[15:0]);
        write_half(w[31:16]);
        if (exp_cnt < 64) exp_mem[exp_cnt] = exp_tx(w, cfg_par_en, cfg_par_even);
        exp_cnt++;
    endtask

    task automatic flags_chk(input int k, input string req);
        logic [4:0] act, exp;
        act = {q_empty, q_half, q_full, q_half_n, q_full_n};
        exp = {k == 0, k >= 16, k == 32, k < 16, k != 32};
        chk(act == exp, req, {27'd0, act}, {27'd0, exp});
    endtask

    task automatic wait_rx(input int n, input int limit, input string req);
        int t = 0;
        while (rx_cnt < n && t < limit) begin @(negedge clk); t++; end
        chk(rx_cnt >= n, req, rx_cnt, n);
    endtask

    task automatic compare_rx(input int n, input string req);
        for (int i = 0; i < n; i++) chk(rx_mem[i] === exp_mem[i], req, rx_mem[i], exp_mem[i]);
    endtask

    task automatic timing_chk(input string req_cell, input string req_gap);
        chk(per_bad == 0 && width_bad == 0, req_cell, per_bad + width_bad, 0);
        chk(both_bad == 0, "R6 pair exclusive", both_bad, 0);
        chk(gap_bad == 0, req_gap, gap_bad, 0);
        chk(quiet_bad == 0, "R11 unused pair quiet", quiet_bad, 0);
    endtask

    // ---------------- watchdog -------------------------------------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=finish", WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- main sequence --------------------------------------
    initial begin
        exp_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        flags_chk(0, "R1 reset flags");
        chk({line_a, line_b, loop_a, loop_b} == 4'b0, "R1 reset lines",
            {line_a, line_b, loop_a, loop_b}, 0);

        // Phase A: two-write load, enable gating, order, fast rate
        mon_clear(1'b0, 10);
        write_half(16'h0080);
        flags_chk(0, "R2 first half does not push");
        write_half(16'h0000);
        flags_chk(1, "R2 second half pushes");
        exp_mem[0] = 32'h0000_0080; exp_cnt = 1;
        push_word(32'h8000_0001);
        push_word(32'hA5C3_1E69);
        flags_chk(3, "R3 three words");
        repeat (60) @(negedge clk);
        chk(rx_cnt == 0 && !line_a && !line_b, "R5 idle while disabled", rx_cnt, 0);
        tx_enable = 1'b1;
        wait_rx(3, 3000, "R5 words sent");
        compare_rx(3, "R7 R2 decoded word");
        timing_chk("R8 fast cell timing R6", "R10 gap");
        repeat (60) @(negedge clk);
        flags_chk(0, "R3 drained");
        tx_enable = 1'b0;

        // Phase B: parity sweep, odd then even
        for (int m = 0; m < 3; m++) begin
            mon_clear(1'b0, 10); exp_cnt = 0;
            cfg_par_en   = (m != 0);
            cfg_par_even = (m == 2);
            for (int i = 0; i < 6; i++)
                push_word((32'h1357_9BDF * (i + 1)) ^ (32'(i) << 29) ^ 32'(m));
            tx_enable = 1'b1;
            wait_rx(6, 4000, "R9 parity words sent");
            compare_rx(6, "R9 bit 32");
            tx_enable = 1'b0;
            repeat (60) @(negedge clk);
        end
        cfg_par_en = 1'b0; cfg_par_even = 1'b0;

        // Phase C: completing write and pop on the same edge
        mon_clear(1'b0, 10); exp_cnt = 0;
        for (int i = 0; i < 16; i++) push_word(32'h0000_0080 | (32'(i) << 12) | 32'(i));
        flags_chk(16, "R3 sixteen words");
        write_half(16'h00F0);
        @(negedge clk);
        tx_enable = 1'b1; wr_en = 1'b1; wr_data = 16'h5A5A;
        @(negedge clk);
        wr_en = 1'b0;
        exp_mem[16] = 32'h5A5A_00F0; exp_cnt = 17;
        flags_chk(16, "R12 level unchanged");
        chk(line_a == 1'b1, "R5 first cell on pop edge", line_a, 1);
        wait_rx(17, 8000, "R12 all words sent");
        compare_rx(17, "R12 order kept");
        timing_chk("R6 cell timing", "R10 gap back to back");
        tx_enable = 1'b0;
        repeat (60) @(negedge clk);

        // Phase D: fill sweep and overflow drop
        mon_clear(1'b0, 10); exp_cnt = 0;
        for (int i = 0; i < 32; i++) begin
            push_word(~(32'h0101_0101 * (i + 3)));
            flags_chk(i + 1, "R3 fill level");
        end
        write_half(16'hDEAD);
        write_half(16'hBEEF);
        flags_chk(32, "R4 write while full");
        write_half(16'h1111);
        tx_enable = 1'b1;
        wait_rx(32, 14000, "R4 queued words sent");
        compare_rx(32, "R4 contents intact");
        repeat (800) @(negedge clk);
        chk(rx_cnt == 32, "R4 no extra word", rx_cnt, 32);
        tx_enable = 1'b0;
        // pairing intact: a fresh pair after drop must form one word
        mon_clear(1'b0, 10); exp_cnt = 0;
        push_word(32'h7E81_0042);
        flags_chk(1, "R4 pairing unaffected");
        tx_enable = 1'b1;
        wait_rx(1, 800, "R4 pair sent");
        compare_rx(1, "R4 pair value");
        tx_enable = 1'b0;
        repeat (60) @(negedge clk);

        // Phase E: slow rate on the loopback pair
        cfg_rate_slow = 1'b1; cfg_run_normal = 1'b0;
        mon_clear(1'b1, 80); exp_cnt = 0;
        push_word(32'hC001_D00D);
        push_word(32'h0F0F_F0F0);
        tx_enable = 1'b1;
        wait_rx(2, 7000, "R11 loopback words");
        compare_rx(2, "R11 loopback value");
        timing_chk("R8 slow cell timing", "R10 slow gap");
        tx_enable = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule